// File: doc/BRIEF.md
# Video Register Decoder and Bus Snooper

This block sits on a 16-bit processor bus next to a tile-and-sprite display engine. It holds the engine's control state: position, attribute and collision words for eight sprites, a display-enable strobe, the graphics mode, four colour-stack entries, a border colour, two pixel delays and an edge-blanking mask. Register reads and writes only take effect while the access-window input is high; outside the window, reads return all ones and writes are dropped.

The same block watches bus writes into two memory regions it does not own, the background card table and the graphics RAM. It does not claim those writes. Each write into a region raises a dirty flag so the renderer knows to refresh. At each frame start the renderer may acknowledge the flags, which clears them. Frame start also latches the display enable for the coming frame. Software must re-arm that enable by writing its register during every vertical blank, or video goes dark for the next frame.

Top module: `vid_reg_snoop`

## Requirements
- R1: Offsets 0x00–0x1F hold the sprite words. Offset bits [4:3] select the kind (0 X, 1 Y, 2 attribute, 3 collision) and bits [2:0] select the sprite. All 16 bits are readable and writable, and a write changes no other word.
- R2: Offset 0x21 stores the mode in bit 0 and drives fgbg_mode_o (1 foreground/background, 0 colour stack). Its other bits read as zero.
- R3: Offsets 0x28–0x2B (colour stack) and 0x2C (border) keep the low 4 bits of the written data. The border value drives border_o.
- R4: Offsets 0x30 and 0x31 keep the low 3 bits as horizontal and vertical pixel delay. Offset 0x32 keeps the low 2 bits as edge blanking: bit 0 is left (edge_left_o) and bit 1 is top (edge_top_o). Upper bits read as zero.
- R5: A read whose address lies in 0x0000–0x003F gives rd_valid_o with rd_data_o on the cycle after the request. Unmapped offsets read zero. A read anywhere else gives no rd_valid_o.
- R6: While win_i is low, register reads return 0xFFFF and register writes change no state.
- R7: A bus write to 0x0200–0x035F sets bt_dirty_o, and a bus write to 0x3800–0x39FF sets gr_dirty_o, on the following cycle whatever win_i is. Addresses just outside these ranges leave the flags alone.
- R8: A frame_i pulse with dirty_ack_i high clears both dirty flags. Without the acknowledge the flags hold. A snooped write in the same cycle as a clear leaves its flag set.
- R9: A windowed write to offset 0x20 arms the enable, and reading 0x20 shows the armed state in bit 0. Each frame_i pulse copies the armed state to disp_en_o and disarms, so video stays on only for frames whose enable was rewritten.
- R10: After reset every register, flag and output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Bus address |
| bus_wdata_i | input | 16 | Bus write data |
| bus_we_i | input | 1 | Bus write strobe |
| bus_re_i | input | 1 | Bus read strobe |
| win_i | input | 1 | Register access window open |
| frame_i | input | 1 | Frame start pulse |
| dirty_ack_i | input | 1 | Renderer has consumed the dirty flags |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 16 | Read data |
| disp_en_o | output | 1 | Display enabled for the current frame |
| fgbg_mode_o | output | 1 | Foreground/background mode selected |
| border_o | output | 4 | Border colour |
| hdelay_o | output | 3 | Horizontal pixel delay |
| vdelay_o | output | 3 | Vertical pixel delay |
| edge_left_o | output | 1 | Blank left edge column |
| edge_top_o | output | 1 | Blank top edge row |
| bt_dirty_o | output | 1 | Background card table written |
| gr_dirty_o | output | 1 | Graphics RAM written |

## Verification
Sprite words are written with distinct patterns at different kind/index pairs, and neighbouring words are read back. This separates a wrong kind-bit decode from a wrong index decode. Narrow registers get over-wide data with all-ones upper bits, which exposes missing truncation. Snooping is tried exactly at each range edge and one address past it, with the window both open and closed, to catch off-by-one limits and wrong gating. Frame pulses are applied with and without acknowledge, with a coincident snooped write, and across enabled and unarmed frames. This shows that the enable lasts one frame only and that the clear yields to a new write.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  localparam int OFFW   = 6;
  localparam int NSPR   = 8;
  localparam int NKIND  = 4;
  localparam int NCS    = 4;
  localparam int DLY_W  = 3;
  localparam int EDGE_W = 2;

  typedef enum logic [1:0] {KIND_X, KIND_Y, KIND_ATTR, KIND_COLL} spr_kind_e;

  localparam logic [OFFW-1:0] OFF_DEN    = 6'h20;
  localparam logic [OFFW-1:0] OFF_MODE   = 6'h21;
  localparam logic [OFFW-1:0] OFF_BORDER = 6'h2C;
  localparam logic [OFFW-1:0] OFF_HDLY   = 6'h30;
  localparam logic [OFFW-1:0] OFF_VDLY   = 6'h31;
  localparam logic [OFFW-1:0] OFF_EDGE   = 6'h32;
  localparam logic [3:0]      CS_PAGE    = 4'hA;  // off[5:2] for 0x28..0x2B

  localparam logic [15:0] DEF_REG_BASE = 16'h0000;
  localparam logic [15:0] DEF_BT_LO    = 16'h0200;
  localparam logic [15:0] DEF_BT_HI    = 16'h035F;
  localparam logic [15:0] DEF_GR_LO    = 16'h3800;
  localparam logic [15:0] DEF_GR_HI    = 16'h39FF;
endpackage

// File: rtl/vrs_decode.sv
module vrs_decode
  import vrs_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [15:0] REG_BASE = DEF_REG_BASE,
  parameter logic [15:0] BT_LO    = DEF_BT_LO,
  parameter logic [15:0] BT_HI    = DEF_BT_HI,
  parameter logic [15:0] GR_LO    = DEF_GR_LO,
  parameter logic [15:0] GR_HI    = DEF_GR_HI
) (
  input  logic [AW-1:0]   addr_i,
  output logic            reg_hit_o,
  output logic [OFFW-1:0] off_o,
  output logic [1:0]      snoop_hit_o
);
  localparam logic [AW-1:0] LO0 = AW'(BT_LO);
  localparam logic [AW-1:0] HI0 = AW'(BT_HI);
  localparam logic [AW-1:0] LO1 = AW'(GR_LO);
  localparam logic [AW-1:0] HI1 = AW'(GR_HI);
  localparam logic [AW-1:0] RB  = AW'(REG_BASE);

  assign reg_hit_o      = addr_i[AW-1:OFFW] == RB[AW-1:OFFW];
  assign off_o          = addr_i[OFFW-1:0];
  assign snoop_hit_o[0] = (addr_i >= LO0) && (addr_i <= HI0);
  assign snoop_hit_o[1] = (addr_i >= LO1) && (addr_i <= HI1);
endmodule

// File: rtl/vrs_regfile.sv
module vrs_regfile
  import vrs_pkg::*;
#(
  parameter int DW   = 16,
  parameter int COLW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              win_i,
  input  logic [OFFW-1:0]   off_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              arm_i,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              mode_o,
  output logic [COLW-1:0]   border_o,
  output logic [DLY_W-1:0]  hdly_o,
  output logic [DLY_W-1:0]  vdly_o,
  output logic [EDGE_W-1:0] edge_o
);
  localparam int IDXW = $clog2(NSPR);
  localparam int KNDW = $clog2(NKIND);

  logic [DW-1:0]     spr_q [NKIND][NSPR];
  logic [COLW-1:0]   cs_q  [NCS];
  logic              mode_q;
  logic [COLW-1:0]   border_q;
  logic [DLY_W-1:0]  hdly_q, vdly_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DW-1:0]     rd_d;

  logic              is_spr;
  logic [KNDW-1:0]   kind;
  logic [IDXW-1:0]   idx;
  assign is_spr = ~off_i[OFFW-1];
  assign kind   = off_i[IDXW+KNDW-1:IDXW];
  assign idx    = off_i[IDXW-1:0];

  genvar gk, gi;
  generate
    for (gk = 0; gk < NKIND; gk++) begin : g_kind
      for (gi = 0; gi < NSPR; gi++) begin : g_spr
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) spr_q[gk][gi] <= '0;
          else if (wr_i && is_spr && kind == KNDW'(gk) && idx == IDXW'(gi))
            spr_q[gk][gi] <= wdata_i;
        end
      end
    end
    for (gi = 0; gi < NCS; gi++) begin : g_cs
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cs_q[gi] <= '0;
        else if (wr_i && off_i[OFFW-1:2] == CS_PAGE && off_i[1:0] == 2'(gi))
          cs_q[gi] <= wdata_i[COLW-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      border_q <= '0;
      hdly_q   <= '0;
      vdly_q   <= '0;
      edge_q   <= '0;
    end else if (wr_i) begin
      case (off_i)
        OFF_MODE:   mode_q   <= wdata_i[0];
        OFF_BORDER: border_q <= wdata_i[COLW-1:0];
        OFF_HDLY:   hdly_q   <= wdata_i[DLY_W-1:0];
        OFF_VDLY:   vdly_q   <= wdata_i[DLY_W-1:0];
        OFF_EDGE:   edge_q   <= wdata_i[EDGE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    if (is_spr) rd_d = spr_q[kind][idx];
    else if (off_i[OFFW-1:2] == CS_PAGE) rd_d[COLW-1:0] = cs_q[off_i[1:0]];
    else begin
      case (off_i)
        OFF_DEN:    rd_d[0]            = arm_i;
        OFF_MODE:   rd_d[0]            = mode_q;
        OFF_BORDER: rd_d[COLW-1:0]     = border_q;
        OFF_HDLY:   rd_d[DLY_W-1:0]    = hdly_q;
        OFF_VDLY:   rd_d[DLY_W-1:0]    = vdly_q;
        OFF_EDGE:   rd_d[EDGE_W-1:0]   = edge_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= win_i ? rd_d : '1;
    end
  end

  assign mode_o   = mode_q;
  assign border_o = border_q;
  assign hdly_o   = hdly_q;
  assign vdly_o   = vdly_q;
  assign edge_o   = edge_q;
endmodule

// File: rtl/vrs_snoop.sv
module vrs_snoop #(
  parameter int NREG = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [NREG-1:0] hit_i,
  input  logic            frame_i,
  input  logic            ack_i,
  output logic [NREG-1:0] dirty_o
);
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                dirty_o[g] <= 1'b0;
        else if (we_i && hit_i[g])  dirty_o[g] <= 1'b1;  // new write beats clear
        else if (frame_i && ack_i)  dirty_o[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/vrs_frame_en.sv
module vrs_frame_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_wr_i,
  input  logic frame_i,
  output logic arm_o,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_o <= 1'b0;
      en_o  <= 1'b0;
    end else begin
      if (frame_i) en_o <= arm_o;
      if (arm_wr_i)     arm_o <= 1'b1;
      else if (frame_i) arm_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_reg_snoop.sv
module vid_reg_snoop
  import vrs_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter int          COLW     = 4,
  parameter logic [15:0] REG_BASE = DEF_REG_BASE,
  parameter logic [15:0] BT_LO    = DEF_BT_LO,
  parameter logic [15:0] BT_HI    = DEF_BT_HI,
  parameter logic [15:0] GR_LO    = DEF_GR_LO,
  parameter logic [15:0] GR_HI    = DEF_GR_HI
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic             win_i,
  input  logic             frame_i,
  input  logic             dirty_ack_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             disp_en_o,
  output logic             fgbg_mode_o,
  output logic [COLW-1:0]  border_o,
  output logic [DLY_W-1:0] hdelay_o,
  output logic [DLY_W-1:0] vdelay_o,
  output logic             edge_left_o,
  output logic             edge_top_o,
  output logic             bt_dirty_o,
  output logic             gr_dirty_o
);
  logic              reg_hit;
  logic [OFFW-1:0]   off;
  logic [1:0]        snoop_hit;
  logic [1:0]        dirty;
  logic              reg_wr, reg_rd, arm;
  logic [EDGE_W-1:0] edge_bits;

  assign reg_wr = bus_we_i & reg_hit & win_i;
  assign reg_rd = bus_re_i & reg_hit;

  vrs_decode #(
    .AW(AW), .REG_BASE(REG_BASE),
    .BT_LO(BT_LO), .BT_HI(BT_HI), .GR_LO(GR_LO), .GR_HI(GR_HI)
  ) u_dec (
    .addr_i     (bus_addr_i),
    .reg_hit_o  (reg_hit),
    .off_o      (off),
    .snoop_hit_o(snoop_hit)
  );

  vrs_regfile #(.DW(DW), .COLW(COLW)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr),
    .rd_i      (reg_rd),
    .win_i     (win_i),
    .off_i     (off),
    .wdata_i   (bus_wdata_i),
    .arm_i     (arm),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o),
    .mode_o    (fgbg_mode_o),
    .border_o  (border_o),
    .hdly_o    (hdelay_o),
    .vdly_o    (vdelay_o),
    .edge_o    (edge_bits)
  );

  vrs_snoop #(.NREG(2)) u_snp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bus_we_i),
    .hit_i  (snoop_hit),
    .frame_i(frame_i),
    .ack_i  (dirty_ack_i),
    .dirty_o(dirty)
  );

  vrs_frame_en u_fen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_wr_i(reg_wr && off == OFF_DEN),
    .frame_i (frame_i),
    .arm_o   (arm),
    .en_o    (disp_en_o)
  );

  assign edge_left_o = edge_bits[0];
  assign edge_top_o  = edge_bits[1];
  assign bt_dirty_o  = dirty[0];
  assign gr_dirty_o  = dirty[1];
endmodule

// File: rtl/vrs_checker.sv
module vrs_checker #(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter logic [15:0] REG_BASE = 16'h0000,
  parameter logic [15:0] BT_LO    = 16'h0200,
  parameter logic [15:0] BT_HI    = 16'h035F
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_we_i,
  input logic          bus_re_i,
  input logic          win_i,
  input logic          frame_i,
  input logic          rd_valid_o,
  input logic [DW-1:0] rd_data_o,
  input logic          disp_en_o,
  input logic [2:0]    hdelay_o,
  input logic [2:0]    vdelay_o,
  input logic          bt_dirty_o
);
  logic in_reg, in_bt;
  assign in_reg = bus_addr_i[AW-1:6] == REG_BASE[AW-1:6];
  assign in_bt  = bus_addr_i >= AW'(BT_LO) && bus_addr_i <= AW'(BT_HI);

  p_rd_resp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_i && in_reg |=> rd_valid_o);
  p_rd_none_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_re_i && in_reg) |=> !rd_valid_o);
  p_rd_closed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_i && in_reg && !win_i |=> rd_data_o == '1);
  p_wr_closed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_i |=> $stable(hdelay_o) && $stable(vdelay_o));
  p_bt_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && in_bt |=> bt_dirty_o);
  p_bt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bt_dirty_o && !frame_i |=> bt_dirty_o);
  p_en_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(disp_en_o));
endmodule

bind vid_reg_snoop vrs_checker #(
  .AW(AW), .DW(DW), .REG_BASE(REG_BASE), .BT_LO(BT_LO), .BT_HI(BT_HI)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_we_i   (bus_we_i),
  .bus_re_i   (bus_re_i),
  .win_i      (win_i),
  .frame_i    (frame_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .disp_en_o  (disp_en_o),
  .hdelay_o   (hdelay_o),
  .vdelay_o   (vdelay_o),
  .bt_dirty_o (bt_dirty_o)
);

// File: tb/sim_vid_reg_snoop.sv
`timescale 1ns/1ps
module sim_vid_reg_snoop;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic        bus_we_i = 1'b0, bus_re_i = 1'b0;
  logic        win_i = 1'b0, frame_i = 1'b0, dirty_ack_i = 1'b0;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;
  logic        disp_en_o, fgbg_mode_o, edge_left_o, edge_top_o;
  logic [3:0]  border_o;
  logic [2:0]  hdelay_o, vdelay_o;
  logic        bt_dirty_o, gr_dirty_o;

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk_i = ~clk_i;

  vid_reg_snoop u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle, driven between falling edges
  task automatic cyc(input logic [15:0] a, input logic [15:0] d, input logic we,
                     input logic re, input logic fs, input logic ack);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = we; bus_re_i = re;
    frame_i = fs; dirty_ack_i = ack;
    @(negedge clk_i);
    bus_we_i = 0; bus_re_i = 0; frame_i = 0; dirty_ack_i = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    cyc(a, d, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] e, input string req);
    exp_q.push_back(e); tag_q.push_back(req);
    cyc(a, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic frame(input logic ack);
    cyc(16'h0100, 16'h0, 1'b0, 1'b0, 1'b1, ack);
  endtask

  // monitor: scoreboard pop
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R5 unexpected read response actual=%0h expected=none", rd_data_o);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {16'h0, rd_data_o}, {16'h0, e});
      end
    end
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10 reset state
    chk("R10", {disp_en_o, fgbg_mode_o, border_o, hdelay_o, vdelay_o,
                edge_left_o, edge_top_o, bt_dirty_o, gr_dirty_o, rd_valid_o}, '0);
    win_i = 1;
    rd(16'h0000, 16'h0000, "R10");
    rd(16'h0032, 16'h0000, "R10");

    // R1 sprite words
    wr(16'h0003, 16'h1234);
    wr(16'h000D, 16'hABCD);
    wr(16'h0010, 16'h5555);
    wr(16'h001F, 16'h00FF);
    rd(16'h0003, 16'h1234, "R1");
    rd(16'h000D, 16'hABCD, "R1");
    rd(16'h0010, 16'h5555, "R1");
    rd(16'h001F, 16'h00FF, "R1");
    rd(16'h0004, 16'h0000, "R1");
    rd(16'h000B, 16'h0000, "R1");
    rd(16'h0013, 16'h0000, "R1");

    // R2 mode
    wr(16'h0021, 16'hFFFF);
    chk("R2", fgbg_mode_o, 1);
    rd(16'h0021, 16'h0001, "R2");
    wr(16'h0021, 16'h0000);
    chk("R2", fgbg_mode_o, 0);

    // R3 colours
    wr(16'h002A, 16'h123F);
    wr(16'h002C, 16'hFFF9);
    rd(16'h002A, 16'h000F, "R3");
    rd(16'h0029, 16'h0000, "R3");
    rd(16'h002C, 16'h0009, "R3");
    chk("R3", border_o, 4'h9);

    // R4 framing
    wr(16'h0030, 16'h00FD);
    wr(16'h0031, 16'h000A);
    wr(16'h0032, 16'hFFFF);
    chk("R4", hdelay_o, 3'd5);
    chk("R4", vdelay_o, 3'd2);
    chk("R4", {edge_top_o, edge_left_o}, 2'b11);
    rd(16'h0032, 16'h0003, "R4");
    wr(16'h0032, 16'h0002);
    chk("R4", {edge_top_o, edge_left_o}, 2'b10);

    // R5 unmapped and outside region
    rd(16'h0025, 16'h0000, "R5");
    rd(16'h003F, 16'h0000, "R5");
    cyc(16'h0100, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);  // no response expected
    chk("R5", rd_valid_o, 0);

    // R6 window closed
    win_i = 0;
    wr(16'h0030, 16'h0000);
    wr(16'h0003, 16'h0000);
    chk("R6", hdelay_o, 3'd5);
    rd(16'h0030, 16'hFFFF, "R6");
    win_i = 1;
    rd(16'h0030, 16'h0005, "R6");
    rd(16'h0003, 16'h1234, "R6");

    // R7 snoop ranges
    chk("R7", {bt_dirty_o, gr_dirty_o}, 2'b00);
    wr(16'h01FF, 16'h1);
    wr(16'h0360, 16'h1);
    chk("R7", bt_dirty_o, 0);
    wr(16'h0200, 16'h1);
    chk("R7", bt_dirty_o, 1);
    win_i = 0;
    wr(16'h37FF, 16'h1);
    wr(16'h3A00, 16'h1);
    chk("R7", gr_dirty_o, 0);
    wr(16'h39FF, 16'h1);
    chk("R7", gr_dirty_o, 1);
    win_i = 1;

    // R8 frame clear
    frame(1'b0);
    chk("R8", {bt_dirty_o, gr_dirty_o}, 2'b11);
    frame(1'b1);
    chk("R8", {bt_dirty_o, gr_dirty_o}, 2'b00);
    wr(16'h035F, 16'h1);
    wr(16'h3800, 16'h1);
    cyc(16'h0300, 16'h1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R8", {bt_dirty_o, gr_dirty_o}, 2'b10);

    // R9 enable latch
    chk("R9", disp_en_o, 0);
    wr(16'h0020, 16'h0000);
    rd(16'h0020, 16'h0001, "R9");
    chk("R9", disp_en_o, 0);
    frame(1'b0);
    chk("R9", disp_en_o, 1);
    rd(16'h0020, 16'h0000, "R9");
    frame(1'b0);
    chk("R9", disp_en_o, 0);
    win_i = 0;
    wr(16'h0020, 16'h0000);
    win_i = 1;
    frame(1'b0);
    chk("R9", disp_en_o, 0);
    wr(16'h0020, 16'h0000);
    frame(1'b0);
    chk("R9", disp_en_o, 1);

    repeat (3) @(negedge clk_i);
    chk("R5", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule